// File: doc/BRIEF.md
# Nibble-Operand Stack Processor Core

This block is a small execution core for a byte-coded stack machine. Every instruction is a single byte. The upper four bits select one of sixteen primary functions and the lower four bits carry an immediate value. Wider or negative constants are assembled over several bytes in an operand register by two prefix functions. One escape function reuses the accumulated operand as a secondary, zero-operand opcode, which gives a small set of arithmetic and compare operations on the three-entry evaluation stack.

The core is built to sit in front of a synchronous, word-wide memory. It issues byte addresses. The memory returns the aligned word one cycle after a read strobe, and the core selects the byte lane it needs for instruction fetches. Execution starts at an address given on an input when reset is released. The workspace pointer starts at zero. An unsupported secondary opcode stops the core and raises a sticky flag. After that the core makes no memory access until the next reset.

Top module: `nibble_stack_core`

## Requirements
- R1: While reset is held, the core presents a read at `bootAddr` with the fault flag low. After release, the first instruction is fetched from `bootAddr`, and the workspace pointer and all stack registers start at zero.
- R2: Instruction byte bit 7..4 is the function and bit 3..0 is ORed into the operand register to form the operand. Functions: 0 J, 1 LDLP, 2 PFIX, 3 LDNL, 4 LDC, 5 LDNLP, 6 NFIX, 7 LDL, 8 ADC, 9 CALL, A CJ, B AJW, C EQC, D STL, E STNL, F OPR. PFIX sets the operand register to the operand shifted left by 4.
- R3: NFIX sets the operand register to the bitwise complement of the operand, shifted left by 4.
- R4: Every function other than PFIX and NFIX clears the operand register when it completes.
- R5: A load pushes (A to B, B to C). Consuming one value moves B to A (or the result to A) and C to B, and leaves C unchanged.
- R6: LDL pushes the word at workspace + operand×4. STL writes A there and pops. LDLP pushes that address. AJW adds operand×4 to the workspace pointer.
- R7: LDNL replaces A with the word at A + operand×4. LDNLP replaces A with that address. STNL writes B there and sets A and B to the old C.
- R8: J sets the instruction pointer to the next byte address + operand. CALL does the same and also pushes that next byte address.
- R9: CJ jumps like J and keeps the stack when A is zero. Otherwise it pops A and continues.
- R10: ADC adds the operand to A. EQC replaces A with 1 if A equals the operand and with 0 otherwise.
- R11: OPR secondary codes: 0 REV swaps A and B. 5 ADD gives B+A. 4 DIFF and C SUB give B−A. 9 GT gives 1 if B > A as signed numbers, else 0. A WSUB gives A + B×4. Codes 4, 5, 9, A and C pop one value.
- R12: Any other secondary operand value halts the core with `illegalHalt` high. While halted there is no read or write, and the flag stays high until reset.
- R13: A read or write is never strobed in the same cycle as the other. A non-load instruction takes two cycles (fetch, execute). A load takes three. A store writes in its execute cycle and is followed directly by a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bootAddr | input | WORD_W | Byte address of the first instruction |
| memAddr | output | WORD_W | Byte address of the current access |
| memRd | output | 1 | Read strobe; data is expected on memRdata one cycle later |
| memWr | output | 1 | Word write strobe |
| memWdata | output | WORD_W | Write data |
| memRdata | input | WORD_W | Aligned word returned for the previous read |
| illegalHalt | output | 1 | Sticky halt flag for an unsupported secondary opcode |

## Verification
The assertions check on every cycle that reads and writes are exclusive, that a store is followed straight away by a fetch, and that a halted core stays halted and quiet. The arithmetic results, the prefix chains, the stack movement, the jump targets and the workspace addressing can only be seen through the bench's scenarios. Those scenarios run short programs and compare the words that the programs store against values worked out by hand. The cycle counts per instruction class and the values shown during reset are also checked only by directed scenarios.

// File: rtl/nsc_pkg.sv
package nsc_pkg;

  typedef enum logic [3:0] {
    FN_J, FN_LDLP, FN_PFIX, FN_LDNL, FN_LDC, FN_LDNLP, FN_NFIX, FN_LDL,
    FN_ADC, FN_CALL, FN_CJ, FN_AJW, FN_EQC, FN_STL, FN_STNL, FN_OPR
  } fnCode_e;

  localparam logic [3:0] SEC_REV  = 4'h0;
  localparam logic [3:0] SEC_DIFF = 4'h4;
  localparam logic [3:0] SEC_ADD  = 4'h5;
  localparam logic [3:0] SEC_GT   = 4'h9;
  localparam logic [3:0] SEC_WSUB = 4'hA;
  localparam logic [3:0] SEC_SUB  = 4'hC;

  typedef enum logic [2:0] {STK_HOLD, STK_PUSH, STK_REPL, STK_POP, STK_POPV, STK_POP2, STK_SWAP} stkOp_e;
  typedef enum logic [2:0] {VAL_OPER, VAL_WADDR, VAL_NADDR, VAL_MEM, VAL_ADC, VAL_EQC, VAL_IPNEXT, VAL_ALU} valSel_e;
  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_GT, ALU_WSUB} aluOp_e;
  typedef enum logic [1:0] {OPER_HOLD, OPER_CLR, OPER_PFIX, OPER_NFIX} operOp_e;
  typedef enum logic [1:0] {IP_HOLD, IP_NEXT, IP_JUMP} ipOp_e;
  typedef enum logic [1:0] {ADR_IP, ADR_WADDR, ADR_NADDR} addrSel_e;

  typedef struct packed {
    stkOp_e   stkOp;
    valSel_e  valSel;
    aluOp_e   aluOp;
    operOp_e  operOp;
    ipOp_e    ipOp;
    addrSel_e addrSel;
    logic     wpAdj;
    logic     wdataB;
  } ctrl_t;

endpackage

// File: rtl/nsc_ctrl.sv
module nsc_ctrl
  import nsc_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        fnCode,
  input  logic [WORD_W-1:0] operFull,
  input  logic              aZero,
  output ctrl_t             ctl,
  output logic              memRd,
  output logic              memWr,
  output logic              illegalHalt
);

  typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_LOAD, ST_HALT} state_e;

  state_e st, stNext;
  logic   loadPush, loadPushNext;
  logic   secWide;

  assign secWide     = |operFull[WORD_W-1:4];
  assign illegalHalt = (st == ST_HALT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_FETCH;
      loadPush <= 1'b0;
    end else begin
      st       <= stNext;
      loadPush <= loadPushNext;
    end
  end

  always_comb begin
    ctl          = '0;
    memRd        = 1'b0;
    memWr        = 1'b0;
    stNext       = st;
    loadPushNext = loadPush;
    case (st)
      ST_FETCH: begin
        ctl.addrSel = ADR_IP;
        memRd       = 1'b1;
        stNext      = ST_EXEC;
      end
      ST_EXEC: begin
        ctl.ipOp   = IP_NEXT;
        ctl.operOp = OPER_CLR;
        stNext     = ST_FETCH;
        case (fnCode_e'(fnCode))
          FN_J:     ctl.ipOp = IP_JUMP;
          FN_LDLP:  begin ctl.stkOp = STK_PUSH; ctl.valSel = VAL_WADDR; end
          FN_PFIX:  ctl.operOp = OPER_PFIX;
          FN_NFIX:  ctl.operOp = OPER_NFIX;
          FN_LDNL:  begin ctl.addrSel = ADR_NADDR; memRd = 1'b1; stNext = ST_LOAD; loadPushNext = 1'b0; end
          FN_LDL:   begin ctl.addrSel = ADR_WADDR; memRd = 1'b1; stNext = ST_LOAD; loadPushNext = 1'b1; end
          FN_LDC:   begin ctl.stkOp = STK_PUSH; ctl.valSel = VAL_OPER; end
          FN_LDNLP: begin ctl.stkOp = STK_REPL; ctl.valSel = VAL_NADDR; end
          FN_ADC:   begin ctl.stkOp = STK_REPL; ctl.valSel = VAL_ADC; end
          FN_CALL:  begin ctl.stkOp = STK_PUSH; ctl.valSel = VAL_IPNEXT; ctl.ipOp = IP_JUMP; end
          FN_CJ:    if (aZero) ctl.ipOp = IP_JUMP; else ctl.stkOp = STK_POP;
          FN_AJW:   ctl.wpAdj = 1'b1;
          FN_EQC:   begin ctl.stkOp = STK_REPL; ctl.valSel = VAL_EQC; end
          FN_STL:   begin ctl.addrSel = ADR_WADDR; memWr = 1'b1; ctl.stkOp = STK_POP; end
          FN_STNL:  begin ctl.addrSel = ADR_NADDR; memWr = 1'b1; ctl.wdataB = 1'b1; ctl.stkOp = STK_POP2; end
          FN_OPR: begin
            ctl.valSel = VAL_ALU;
            ctl.stkOp  = STK_POPV;
            if (secWide) begin
              ctl.stkOp = STK_HOLD;
              stNext    = ST_HALT;
            end else begin
              case (operFull[3:0])
                SEC_REV:  ctl.stkOp = STK_SWAP;
                SEC_ADD:  ctl.aluOp = ALU_ADD;
                SEC_DIFF,
                SEC_SUB:  ctl.aluOp = ALU_SUB;
                SEC_GT:   ctl.aluOp = ALU_GT;
                SEC_WSUB: ctl.aluOp = ALU_WSUB;
                default: begin
                  ctl.stkOp = STK_HOLD;
                  stNext    = ST_HALT;
                end
              endcase
            end
          end
          default: ;
        endcase
      end
      ST_LOAD: begin
        ctl.stkOp  = loadPush ? STK_PUSH : STK_REPL;
        ctl.valSel = VAL_MEM;
        stNext     = ST_FETCH;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/nsc_dp.sv
module nsc_dp
  import nsc_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] bootAddr,
  input  ctrl_t             ctl,
  input  logic [WORD_W-1:0] memRdata,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [3:0]        fnCode,
  output logic [WORD_W-1:0] operFull,
  output logic              aZero
);

  localparam int BYTES  = WORD_W / 8;
  localparam int LANE_W = $clog2(BYTES);

  logic [WORD_W-1:0] aReg, bReg, cReg, wpReg, ipReg, operReg;
  logic [WORD_W-1:0] laneWord, scaled, wAddr, nAddr, ipNext, aluRes, newVal;
  logic [7:0]        instrByte;

  assign laneWord  = memRdata >> {ipReg[LANE_W-1:0], 3'b000};
  assign instrByte = laneWord[7:0];
  assign fnCode    = instrByte[7:4];
  assign operFull  = operReg | {{(WORD_W-4){1'b0}}, instrByte[3:0]};
  assign scaled    = operFull << LANE_W;
  assign wAddr     = wpReg + scaled;
  assign nAddr     = aReg + scaled;
  assign ipNext    = ipReg + 1'b1;
  assign aZero     = (aReg == '0);
  assign memWdata  = ctl.wdataB ? bReg : aReg;

  always_comb begin
    case (ctl.aluOp)
      ALU_ADD:  aluRes = bReg + aReg;
      ALU_SUB:  aluRes = bReg - aReg;
      ALU_GT:   aluRes = {{(WORD_W-1){1'b0}}, $signed(bReg) > $signed(aReg)};
      default:  aluRes = aReg + (bReg << LANE_W);
    endcase
  end

  always_comb begin
    case (ctl.valSel)
      VAL_OPER:   newVal = operFull;
      VAL_WADDR:  newVal = wAddr;
      VAL_NADDR:  newVal = nAddr;
      VAL_MEM:    newVal = memRdata;
      VAL_ADC:    newVal = aReg + operFull;
      VAL_EQC:    newVal = {{(WORD_W-1){1'b0}}, aReg == operFull};
      VAL_IPNEXT: newVal = ipNext;
      default:    newVal = aluRes;
    endcase
  end

  always_comb begin
    case (ctl.addrSel)
      ADR_WADDR: memAddr = wAddr;
      ADR_NADDR: memAddr = nAddr;
      default:   memAddr = ipReg;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg    <= '0;
      bReg    <= '0;
      cReg    <= '0;
      wpReg   <= '0;
      ipReg   <= bootAddr;
      operReg <= '0;
    end else begin
      case (ctl.stkOp)
        STK_PUSH: begin aReg <= newVal; bReg <= aReg; cReg <= bReg; end
        STK_REPL: aReg <= newVal;
        STK_POP:  begin aReg <= bReg; bReg <= cReg; end
        STK_POPV: begin aReg <= newVal; bReg <= cReg; end
        STK_POP2: begin aReg <= cReg; bReg <= cReg; end
        STK_SWAP: begin aReg <= bReg; bReg <= aReg; end
        default: ;
      endcase
      case (ctl.ipOp)
        IP_NEXT: ipReg <= ipNext;
        IP_JUMP: ipReg <= ipNext + operFull;
        default: ;
      endcase
      if (ctl.wpAdj) wpReg <= wAddr;
      case (ctl.operOp)
        OPER_CLR:  operReg <= '0;
        OPER_PFIX: operReg <= operFull << 4;
        OPER_NFIX: operReg <= (~operFull) << 4;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/nibble_stack_core.sv
module nibble_stack_core
  import nsc_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] bootAddr,
  output logic [WORD_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata,
  output logic              illegalHalt
);

  ctrl_t             ctl;
  logic [3:0]        fnCode;
  logic [WORD_W-1:0] operFull;
  logic              aZero;

  nsc_ctrl #(.WORD_W(WORD_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .fnCode(fnCode), .operFull(operFull), .aZero(aZero),
    .ctl(ctl), .memRd(memRd), .memWr(memWr), .illegalHalt(illegalHalt)
  );

  nsc_dp #(.WORD_W(WORD_W)) i_dp (
    .clk(clk), .rstN(rstN), .bootAddr(bootAddr), .ctl(ctl), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .fnCode(fnCode), .operFull(operFull), .aZero(aZero)
  );

endmodule

// File: rtl/nibble_stack_core_chk.sv
module nibble_stack_core_chk (
  input logic clk,
  input logic rstN,
  input logic memRd,
  input logic memWr,
  input logic illegalHalt
);

  p_excl_access_r13: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  p_store_then_fetch_r13: assert property (@(posedge clk) disable iff (!rstN)
    memWr |=> (memRd && !memWr));

  p_halt_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    illegalHalt |-> (!memRd && !memWr));

  p_halt_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
    illegalHalt |=> illegalHalt);

endmodule

bind nibble_stack_core nibble_stack_core_chk i_chk (
  .clk(clk), .rstN(rstN), .memRd(memRd), .memWr(memWr), .illegalHalt(illegalHalt)
);

// File: tb/test_nibble_stack_core.sv
`timescale 1ns/1ps
module test_nibble_stack_core;

  localparam int WORD_W    = 32;
  localparam int MEM_WORDS = 256;
  localparam logic [31:0] BASE = 32'h200;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] memAddr, memWdata, memRdata;
  logic        memRd, memWr, illegalHalt;

  logic [31:0] mem [MEM_WORDS];
  logic        clrReq = 1'b0, ldEn = 1'b0;
  logic [31:0] ldAddr = '0;
  logic [7:0]  ldByte = '0;
  logic [31:0] progPtr;
  int nChecks = 0, nFail = 0;

  always #10 clk = ~clk;

  nibble_stack_core #(.WORD_W(WORD_W)) i_nibble_stack_core (
    .clk(clk), .rstN(rstN), .bootAddr(BASE), .memAddr(memAddr), .memRd(memRd),
    .memWr(memWr), .memWdata(memWdata), .memRdata(memRdata), .illegalHalt(illegalHalt)
  );

  always @(posedge clk) begin
    if (clrReq) begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
    end else if (ldEn) begin
      mem[ldAddr[9:2]][{ldAddr[1:0], 3'b000} +: 8] = ldByte;
    end
    if (memRd) memRdata <= mem[memAddr[9:2]];
    if (memWr) mem[memAddr[9:2]] = memWdata;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chkWord(input string tag, input int idx, input logic [31:0] exp);
    check(tag, mem[idx], exp);
  endtask

  task automatic beginProg();
    @(negedge clk); rstN = 1'b0; clrReq = 1'b1;
    @(negedge clk); clrReq = 1'b0;
    progPtr = BASE;
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk); ldEn = 1'b1; ldAddr = progPtr; ldByte = b;
    @(negedge clk); ldEn = 1'b0;
    progPtr++;
  endtask

  task automatic runProg(output int cyc);
    put(8'hF1);
    @(negedge clk); rstN = 1'b1;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!illegalHalt && cyc < 4000);
    if (!illegalHalt) check("R12 program did not halt", 32'd0, 32'd1);
  endtask

  task automatic ajw32();
    put(8'h22); put(8'hB0);
  endtask

  task automatic tReset();
    int cyc;
    beginProg();
    @(negedge clk);
    check("R1 reset address", memAddr, BASE);
    check("R1 reset read strobe", {31'd0, memRd}, 32'd1);
    check("R1 reset no write", {31'd0, memWr}, 32'd0);
    check("R1 reset flag low", {31'd0, illegalHalt}, 32'd0);
    put(8'h13); put(8'hD0);
    runProg(cyc);
    chkWord("R1 R6 workspace starts at zero", 0, 32'd12);
  endtask

  task automatic tConst();
    int cyc;
    beginProg(); ajw32();
    put(8'h45); put(8'hD0);
    put(8'h21); put(8'h22); put(8'h43); put(8'hD1);
    put(8'h60); put(8'h4F); put(8'hD2);
    put(8'h6F); put(8'h40); put(8'hD3);
    put(8'h43); put(8'h44); put(8'hD4); put(8'hD5);
    runProg(cyc);
    chkWord("R2 short constant", 32, 32'd5);
    chkWord("R2 prefix chain", 33, 32'h123);
    chkWord("R3 negative prefix -1", 34, 32'hFFFF_FFFF);
    chkWord("R3 negative prefix -256", 35, 32'hFFFF_FF00);
    chkWord("R4 operand cleared", 36, 32'd4);
    chkWord("R5 second stack entry", 37, 32'd3);
  endtask

  task automatic tAlu();
    int cyc;
    beginProg(); ajw32();
    put(8'h47); put(8'h43); put(8'hFC); put(8'hD0);
    put(8'h47); put(8'h43); put(8'hF0); put(8'hFC); put(8'hD1);
    put(8'h42); put(8'h49); put(8'hF5); put(8'hD2);
    put(8'h49); put(8'h42); put(8'hF9); put(8'hD3);
    put(8'h42); put(8'h49); put(8'hF9); put(8'hD4);
    put(8'h60); put(8'h4F); put(8'h41); put(8'hF9); put(8'hD5);
    put(8'h43); put(8'h21); put(8'h40); put(8'hFA); put(8'hD6);
    put(8'h4A); put(8'h43); put(8'hF4); put(8'hD7);
    put(8'h41); put(8'h42); put(8'h43); put(8'hF5); put(8'hF5); put(8'hD8);
    runProg(cyc);
    chkWord("R11 SUB", 32, 32'd4);
    chkWord("R11 REV then SUB", 33, 32'hFFFF_FFFC);
    chkWord("R11 ADD", 34, 32'd11);
    chkWord("R11 GT true", 35, 32'd1);
    chkWord("R11 GT false", 36, 32'd0);
    chkWord("R11 GT signed", 37, 32'd0);
    chkWord("R11 WSUB", 38, 32'h1C);
    chkWord("R11 DIFF", 39, 32'd7);
    chkWord("R5 C moves to B on pop", 40, 32'd6);
  endtask

  task automatic tMem();
    int cyc;
    beginProg(); ajw32();
    put(8'h45); put(8'hD0);
    put(8'h21); put(8'h22); put(8'h43); put(8'hD1);
    put(8'h70); put(8'h83); put(8'hD8);
    put(8'h11); put(8'h30); put(8'hD9);
    put(8'h10); put(8'h52); put(8'hDA);
    put(8'h27); put(8'h47); put(8'h1B); put(8'hE0);
    put(8'h10); put(8'h31); put(8'hDC);
    put(8'hB1); put(8'h49); put(8'hD0);
    runProg(cyc);
    chkWord("R6 LDL", 40, 32'd8);
    chkWord("R7 LDNL", 41, 32'h123);
    chkWord("R7 LDNLP", 42, 32'h88);
    chkWord("R7 STNL", 43, 32'h77);
    chkWord("R7 LDNL offset", 44, 32'h123);
    chkWord("R6 AJW one word", 33, 32'd9);
  endtask

  task automatic tFlow();
    int cyc;
    logic [31:0] callAt;
    beginProg(); ajw32();
    put(8'h46); put(8'h40); put(8'hA1); put(8'h41); put(8'hD0); put(8'hD1);
    put(8'h46); put(8'h43); put(8'hA1); put(8'h42); put(8'hD2); put(8'hD3);
    put(8'h01); put(8'h4F); put(8'h44); put(8'hD4);
    callAt = progPtr;
    put(8'h91); put(8'h4E); put(8'hD5);
    put(8'h45); put(8'hC5); put(8'hD6);
    put(8'h45); put(8'hC4); put(8'hD7);
    put(8'h41); put(8'h21); put(8'h83); put(8'hD8);
    runProg(cyc);
    chkWord("R9 CJ taken keeps A", 32, 32'd0);
    chkWord("R9 CJ taken keeps B", 33, 32'd6);
    chkWord("R9 CJ not taken pops", 34, 32'd2);
    chkWord("R9 CJ not taken below", 35, 32'd6);
    chkWord("R8 J skips byte", 36, 32'd4);
    chkWord("R8 CALL return address", 37, callAt + 32'd1);
    chkWord("R10 EQC equal", 38, 32'd1);
    chkWord("R10 EQC differ", 39, 32'd0);
    chkWord("R10 ADC prefixed", 40, 32'h14);
  endtask

  task automatic tTiming();
    int cyc;
    beginProg();
    put(8'h45); put(8'hD0);
    runProg(cyc);
    check("R13 two-cycle instructions", cyc, 32'd6);
    beginProg();
    put(8'h70);
    runProg(cyc);
    check("R13 three-cycle load", cyc, 32'd5);
  endtask

  task automatic tIllegal();
    int cyc;
    logic busy;
    beginProg(); ajw32();
    put(8'h47); put(8'hD0);
    put(8'h21); put(8'hF0);
    put(8'h49); put(8'hD1);
    runProg(cyc);
    busy = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (memRd || memWr || !illegalHalt) busy = 1'b1;
    end
    check("R12 halted core quiet and flagged", {31'd0, busy}, 32'd0);
    chkWord("R12 store before halt", 32, 32'd7);
    chkWord("R12 nothing after halt", 33, 32'd0);
    beginProg();
    check("R12 reset clears flag", {31'd0, illegalHalt}, 32'd0);
  endtask

  initial begin
    tReset();
    tConst();
    tAlu();
    tMem();
    tFlow();
    tTiming();
    tIllegal();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule